// File: doc/BRIEF.md
# Keyboard Controller Command Engine

This block is the host-facing command processor of a PC-style keyboard controller. The host reaches it through two byte-wide ports that one address bit selects. Address 0 is the data port and address 1 is the command port. Command bytes either act at once or are latched as a pending write target. When a target is latched, the next data-port byte goes to that target, and the latch then clears.

The block owns the controller mode byte, a status byte and the output port byte. The A20 gate line follows bit 1 of the output port. Reply bytes and injected bytes leave through a single-entry valid/ready slot, tagged for either the keyboard receive stream or the auxiliary receive stream. Bytes meant for the attached devices leave as one-cycle strobes. The serial line protocol and the devices themselves are outside this block.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset, mode_o is 0x03, status_o is 0x18, outport_o is 0xCF, a20_o is 1, xlat_en_o is 0, and no strobe or reply is valid.
- R2: Command bytes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 change no visible state when written. Each one is latched as the target of the next data-port write. After that write the latch is empty, so the following data byte goes to the keyboard device.
- R3: A data-port write with no target latched produces, one cycle later, a single-cycle dev_tx_valid with dev_tx_aux=0 and dev_tx_data equal to the byte.
- R4: A data byte written under target 0x60 becomes mode_o. xlat_en_o equals bit 6 of that mode.
- R5: Under target 0xD2 the data byte is placed in the reply slot with rx_aux=0. Under 0xD3 it is placed there with rx_aux=1. Under 0xD4 it is sent as a dev_tx_valid strobe with dev_tx_aux=1.
- R6: A data byte written under target 0xD1 becomes outport_o, and a20_o takes its bit 1. If bit 0 of the byte is 0, sys_reset_o pulses high for exactly one cycle.
- R7: Each of the following commands places a reply in the slot with rx_aux=0. 0x20 replies with mode_o. 0xAA sets status bit 2 and replies 0x55. 0xA9 and 0xAB reply 0x00. 0xC0 replies 0x80. 0xD0 replies with outport_o.
- R8: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it. No other mode bit changes.
- R9: 0xDD clears outport bit 1 and drives a20_o low. 0xDF sets outport bit 1 and drives a20_o high.
- R10: A command whose upper nibble is 0xF pulses sys_reset_o for one cycle when its bit 0 is 0. When its bit 0 is 1 it has no effect.
- R11: A command byte not named in R2 and R7 to R10 leaves mode, status, output port and any latched target unchanged. It produces no reply, no strobe and no reset.
- R12: A reply stays valid and stable until the cycle after it is accepted with rx_ready. A new reply that arrives while the slot is full, including in the cycle of acceptance, replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | 1 | 0 = data port, 1 = command port |
| host_wdata | input | 8 | Host write byte |
| status_o | output | 8 | Status byte (bit 2 = self-test done) |
| mode_o | output | 8 | Controller mode byte |
| outport_o | output | 8 | Output port byte |
| a20_o | output | 1 | A20 gate, equal to outport bit 1 |
| xlat_en_o | output | 1 | Scan-code translation enable, equal to mode bit 6 |
| sys_reset_o | output | 1 | One-cycle system reset request |
| dev_tx_valid | output | 1 | Byte strobe toward a device |
| dev_tx_aux | output | 1 | 0 = keyboard device, 1 = auxiliary device |
| dev_tx_data | output | 8 | Byte toward the device |
| rx_valid | output | 1 | Reply slot holds a byte |
| rx_aux | output | 1 | 0 = keyboard stream, 1 = auxiliary stream |
| rx_data | output | 8 | Reply byte |
| rx_ready | input | 1 | Receive buffer accepts the reply |

## Verification
Two functions can collide in the reply slot: the receive buffer can accept the held byte in the same cycle that a new command produces a reply. The bench holds rx_ready high across a 0xC0 command while an earlier reply is still waiting. It then checks that the slot stays valid and holds 0x80, which means the new byte won over the clearing. A per-clock behavioural model also judges the replacement of an unaccepted reply and the handover of the output port between the 0xD1 data path and the 0xDD/0xDF commands.

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine #(
  parameter logic [7:0] MODE_INIT  = 8'h03,
  parameter logic [7:0] STAT_INIT  = 8'h18,
  parameter logic [7:0] OPORT_INIT = 8'hCF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] status_o,
  output logic [7:0] mode_o,
  output logic [7:0] outport_o,
  output logic       a20_o,
  output logic       xlat_en_o,
  output logic       sys_reset_o,
  output logic       dev_tx_valid,
  output logic       dev_tx_aux,
  output logic [7:0] dev_tx_data,
  output logic       rx_valid,
  output logic       rx_aux,
  output logic [7:0] rx_data,
  input  logic       rx_ready
);
  logic [7:0] mode_q, stat_q, oport_q, tgt_q;
  logic       rep_v, rep_aux;
  logic [7:0] rep_d;

  wire cmd_wr   = host_wr & host_addr;
  wire dat_wr   = host_wr & ~host_addr;
  wire fold_rst = (host_wdata[7:4] == 4'hF) & ~host_wdata[0];
  wire is_latch = (host_wdata == 8'h60) | (host_wdata == 8'hD1) | (host_wdata == 8'hD2) |
                  (host_wdata == 8'hD3) | (host_wdata == 8'hD4);

  assign status_o  = stat_q;
  assign mode_o    = mode_q;
  assign outport_o = oport_q;
  assign a20_o     = oport_q[1];
  assign xlat_en_o = mode_q[6];

  always_comb begin
    rep_v   = 1'b0;
    rep_aux = 1'b0;
    rep_d   = 8'h00;
    if (cmd_wr) begin
      case (host_wdata)
        8'h20:        begin rep_v = 1'b1; rep_d = mode_q;  end
        8'hAA:        begin rep_v = 1'b1; rep_d = 8'h55;   end
        8'hA9, 8'hAB: begin rep_v = 1'b1; rep_d = 8'h00;   end
        8'hC0:        begin rep_v = 1'b1; rep_d = 8'h80;   end
        8'hD0:        begin rep_v = 1'b1; rep_d = oport_q; end
        default: ;
      endcase
    end else if (dat_wr) begin
      if (tgt_q == 8'hD2) begin rep_v = 1'b1; rep_d = host_wdata; end
      if (tgt_q == 8'hD3) begin rep_v = 1'b1; rep_aux = 1'b1; rep_d = host_wdata; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= MODE_INIT;
      stat_q       <= STAT_INIT;
      oport_q      <= OPORT_INIT;
      tgt_q        <= 8'h00;
      sys_reset_o  <= 1'b0;
      dev_tx_valid <= 1'b0;
      dev_tx_aux   <= 1'b0;
      dev_tx_data  <= 8'h00;
      rx_valid     <= 1'b0;
      rx_aux       <= 1'b0;
      rx_data      <= 8'h00;
    end else begin
      sys_reset_o  <= 1'b0;
      dev_tx_valid <= 1'b0;
      if (cmd_wr) begin
        if (is_latch) tgt_q <= host_wdata;
        case (host_wdata)
          8'hAA: stat_q[2]  <= 1'b1;
          8'hA7: mode_q[5]  <= 1'b1;
          8'hA8: mode_q[5]  <= 1'b0;
          8'hAD: mode_q[4]  <= 1'b1;
          8'hAE: mode_q[4]  <= 1'b0;
          8'hDD: oport_q[1] <= 1'b0;
          8'hDF: oport_q[1] <= 1'b1;
          default: ;
        endcase
        if (fold_rst) sys_reset_o <= 1'b1;
      end
      if (dat_wr) begin
        tgt_q <= 8'h00;
        case (tgt_q)
          8'h00: begin dev_tx_valid <= 1'b1; dev_tx_aux <= 1'b0; dev_tx_data <= host_wdata; end
          8'hD4: begin dev_tx_valid <= 1'b1; dev_tx_aux <= 1'b1; dev_tx_data <= host_wdata; end
          8'h60: mode_q <= host_wdata;
          8'hD1: begin oport_q <= host_wdata; sys_reset_o <= ~host_wdata[0]; end
          default: ;
        endcase
      end
      if (rep_v) begin
        rx_valid <= 1'b1;
        rx_aux   <= rep_aux;
        rx_data  <= rep_d;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbc_cmd_engine_chk.sv
module kbc_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_addr,
  input logic [7:0] host_wdata,
  input logic [7:0] status_o,
  input logic [7:0] mode_o,
  input logic [7:0] outport_o,
  input logic       a20_o,
  input logic       sys_reset_o,
  input logic       dev_tx_valid,
  input logic       rx_valid,
  input logic       rx_aux,
  input logic [7:0] rx_data,
  input logic       rx_ready
);
  p_tx_from_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid |-> $past(host_wr && !host_addr));

  p_reset_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_o |-> $past(host_wr));

  p_a20_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr && host_wdata == 8'hDF) |=> a20_o);

  p_a20_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr && host_wdata == 8'hDD) |=> !a20_o);

  p_quiet_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> ($stable(mode_o) && $stable(outport_o) && $stable(status_o)));

  p_selftest_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[2] |=> status_o[2]);

  p_reply_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !host_wr) |=> (rx_valid && $stable(rx_data) && $stable(rx_aux)));
endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (.*);

// File: tb/tb_kbc_cmd_engine.sv
module tb_kbc_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_addr = 1'b0, rx_ready = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] status_o, mode_o, outport_o, dev_tx_data, rx_data;
  logic a20_o, xlat_en_o, sys_reset_o, dev_tx_valid, dev_tx_aux, rx_valid, rx_aux;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_cmd_engine dut (.*);

  // behavioural reference
  byte unsigned m_mode, m_stat, m_port, m_tgt, m_txd, m_rxd;
  bit m_rst, m_txv, m_txa, m_rxv, m_rxa;

  always @(posedge clk) begin
    bit nv, na; byte unsigned nd;
    if (!rst_n) begin
      m_mode = 8'h03; m_stat = 8'h18; m_port = 8'hCF; m_tgt = 0;
      m_rst = 0; m_txv = 0; m_txa = 0; m_txd = 0; m_rxv = 0; m_rxa = 0; m_rxd = 0;
    end else begin
      nv = 0; na = 0; nd = 0;
      m_rst = 0; m_txv = 0;
      if (host_wr && host_addr) begin
        if (host_wdata inside {8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4}) m_tgt = host_wdata;
        else if (host_wdata == 8'h20) begin nv = 1; nd = m_mode; end
        else if (host_wdata == 8'hAA) begin nv = 1; nd = 8'h55; m_stat = m_stat | 8'h04; end
        else if (host_wdata == 8'hA9 || host_wdata == 8'hAB) begin nv = 1; nd = 0; end
        else if (host_wdata == 8'hC0) begin nv = 1; nd = 8'h80; end
        else if (host_wdata == 8'hD0) begin nv = 1; nd = m_port; end
        else if (host_wdata == 8'hA7) m_mode = m_mode | 8'h20;
        else if (host_wdata == 8'hA8) m_mode = m_mode & 8'hDF;
        else if (host_wdata == 8'hAD) m_mode = m_mode | 8'h10;
        else if (host_wdata == 8'hAE) m_mode = m_mode & 8'hEF;
        else if (host_wdata == 8'hDD) m_port = m_port & 8'hFD;
        else if (host_wdata == 8'hDF) m_port = m_port | 8'h02;
        else if (host_wdata >= 8'hF0 && (host_wdata % 2) == 0) m_rst = 1;
      end else if (host_wr) begin
        if (m_tgt == 0) begin m_txv = 1; m_txa = 0; m_txd = host_wdata; end
        else if (m_tgt == 8'hD4) begin m_txv = 1; m_txa = 1; m_txd = host_wdata; end
        else if (m_tgt == 8'h60) m_mode = host_wdata;
        else if (m_tgt == 8'hD1) begin m_port = host_wdata; m_rst = (host_wdata % 2) == 0; end
        else if (m_tgt == 8'hD2) begin nv = 1; nd = host_wdata; end
        else if (m_tgt == 8'hD3) begin nv = 1; na = 1; nd = host_wdata; end
        m_tgt = 0;
      end
      if (nv) begin m_rxv = 1; m_rxa = na; m_rxd = nd; end
      else if (rx_ready) m_rxv = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(mode_o == m_mode, "R8 mode model", mode_o, m_mode);
    chk(status_o == m_stat, "R7 status model", status_o, m_stat);
    chk(outport_o == m_port, "R6 outport model", outport_o, m_port);
    chk(a20_o == m_port[1], "R9 a20 model", a20_o, m_port[1]);
    chk(xlat_en_o == m_mode[6], "R4 xlat model", xlat_en_o, m_mode[6]);
    chk(sys_reset_o == m_rst, "R10 reset model", sys_reset_o, m_rst);
    chk(dev_tx_valid == m_txv && (!m_txv || (dev_tx_aux == m_txa && dev_tx_data == m_txd)),
        "R3 tx model", {dev_tx_valid, dev_tx_aux, dev_tx_data}, {m_txv, m_txa, m_txd});
    chk(rx_valid == m_rxv && (!m_rxv || (rx_aux == m_rxa && rx_data == m_rxd)),
        "R12 rx model", {rx_valid, rx_aux, rx_data}, {m_rxv, m_rxa, m_rxd});
  end

  task automatic wr(input bit a, input byte unsigned d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode_o == 8'h03 && status_o == 8'h18 && outport_o == 8'hCF, "R1 reset regs",
        {mode_o, status_o, outport_o}, 24'h0318CF);
    chk(a20_o && !xlat_en_o && !rx_valid && !dev_tx_valid && !sys_reset_o, "R1 reset outs",
        {a20_o, xlat_en_o, rx_valid}, 3'b100);

    wr(1, 8'h20); chk(rx_valid && rx_data == 8'h03 && !rx_aux, "R7 read mode", rx_data, 8'h03);
    wr(1, 8'hAA); chk(rx_data == 8'h55 && status_o == 8'h1C, "R7 self test", {status_o, rx_data}, 16'h1C55);
    wr(1, 8'hA9); chk(rx_data == 8'h00, "R7 aux test", rx_data, 0);
    wr(1, 8'hC0); chk(rx_data == 8'h80, "R7 input port", rx_data, 8'h80);
    wr(1, 8'hD0); chk(rx_data == 8'hCF, "R7 read outport", rx_data, 8'hCF);
    repeat (2) @(negedge clk);
    chk(rx_valid && rx_data == 8'hCF, "R12 held unaccepted", rx_data, 8'hCF);
    accept(); chk(!rx_valid, "R12 accepted clears", rx_valid, 0);

    wr(0, 8'h5A); chk(dev_tx_valid && !dev_tx_aux && dev_tx_data == 8'h5A, "R3 kbd forward", dev_tx_data, 8'h5A);
    @(negedge clk); chk(!dev_tx_valid, "R3 single strobe", dev_tx_valid, 0);

    wr(1, 8'h60); chk(mode_o == 8'h03 && !dev_tx_valid && !rx_valid, "R2 latch no effect", mode_o, 8'h03);
    wr(0, 8'h47); chk(mode_o == 8'h47 && xlat_en_o, "R4 mode write", {xlat_en_o, mode_o}, 9'h147);
    wr(0, 8'h11); chk(dev_tx_valid && dev_tx_data == 8'h11 && mode_o == 8'h47, "R2 latch cleared", dev_tx_data, 8'h11);

    wr(1, 8'hA7); chk(mode_o == 8'h67, "R8 aux disable", mode_o, 8'h67);
    wr(1, 8'hA8); chk(mode_o == 8'h47, "R8 aux enable", mode_o, 8'h47);
    wr(1, 8'hAD); chk(mode_o == 8'h57, "R8 kbd disable", mode_o, 8'h57);
    wr(1, 8'hAE); chk(mode_o == 8'h47, "R8 kbd enable", mode_o, 8'h47);

    wr(1, 8'hD2); wr(0, 8'h33); chk(rx_valid && !rx_aux && rx_data == 8'h33, "R5 kbd inject", rx_data, 8'h33);
    wr(1, 8'hD3); wr(0, 8'h44); chk(rx_valid && rx_aux && rx_data == 8'h44, "R5 aux inject", {rx_aux, rx_data}, 9'h144);
    wr(1, 8'hD4); wr(0, 8'h99); chk(dev_tx_valid && dev_tx_aux && dev_tx_data == 8'h99, "R5 aux forward", dev_tx_data, 8'h99);
    accept();

    wr(1, 8'hDD); chk(outport_o == 8'hCD && !a20_o, "R9 a20 off", outport_o, 8'hCD);
    wr(1, 8'hDF); chk(outport_o == 8'hCF && a20_o, "R9 a20 on", outport_o, 8'hCF);

    wr(1, 8'hD1); wr(0, 8'hCD);
    chk(outport_o == 8'hCD && !a20_o && !sys_reset_o, "R6 outport no reset", outport_o, 8'hCD);
    wr(1, 8'hD1); wr(0, 8'hCE);
    chk(outport_o == 8'hCE && a20_o && sys_reset_o, "R6 outport reset", {sys_reset_o, outport_o}, 9'h1CE);
    @(negedge clk); chk(!sys_reset_o, "R6 pulse one cycle", sys_reset_o, 0);

    wr(1, 8'hF0); chk(sys_reset_o, "R10 fold F0", sys_reset_o, 1);
    wr(1, 8'hFE); chk(sys_reset_o, "R10 fold FE", sys_reset_o, 1);
    wr(1, 8'hFF); chk(!sys_reset_o, "R10 fold FF", sys_reset_o, 0);
    wr(1, 8'hF5); chk(!sys_reset_o && outport_o == 8'hCE, "R10 fold F5", sys_reset_o, 0);

    wr(1, 8'hD2); wr(1, 8'h12);
    chk(mode_o == 8'h47 && outport_o == 8'hCE && status_o == 8'h1C && !rx_valid && !dev_tx_valid,
        "R11 unknown cmd", {mode_o, outport_o}, 16'h47CE);
    wr(0, 8'h66); chk(rx_valid && rx_data == 8'h66, "R11 latch kept", rx_data, 8'h66);

    wr(1, 8'hAB); chk(rx_data == 8'h00, "R12 replace waiting", rx_data, 0);
    @(negedge clk);
    rx_ready = 1'b1; host_wr = 1'b1; host_addr = 1'b1; host_wdata = 8'hC0;
    @(negedge clk);
    host_wr = 1'b0; rx_ready = 1'b0;
    chk(rx_valid && rx_data == 8'h80, "R12 collide new wins", {rx_valid, rx_data}, 9'h180);
    accept(); chk(!rx_valid, "R12 final accept", rx_valid, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule